// File: doc/BRIEF.md
# Second/Minute Time Base Interrupt Generator

This block turns a 32.768 kHz clock into two periodic events: one tick per second and one tick per minute. A three-state controller watches an enable bit and a rate-select bit. Per-second and per-minute ticks set two sticky interrupt flags: MIN, which software sees at bit 7 of its interrupt register, and SEC, at bit 6. Both flags clear when that register is read. The OR of the flags drives the shared interrupt request.

With the enable bit low, the divider chain is held at zero and no flag can be set, whatever the select bit says. The clock keeps running. With the enable bit high and the select bit low, only MIN is produced. With both bits high, SEC is produced every second and MIN every minute. The division ratios are parameters. The defaults are 32768 cycles per second and 60 seconds per minute.

Controller states:
- `ST_OFF`: chain held at zero.
- `ST_SEC`: second rate.
- `ST_MIN`: minute rate.

Transitions, all decided at each clock edge:
- `T_DISABLE` goes to `ST_OFF` whenever the enable bit is low.
- `T_PICK_SEC` goes to `ST_SEC` when the enable bit is high and the select bit is high.
- `T_PICK_MIN` goes to `ST_MIN` when the enable bit is high and the select bit is low.

Moving between `ST_SEC` and `ST_MIN` keeps the count. Leaving `ST_OFF` starts the count from zero.

Top module: `tbase_timebase`

## Requirements
- R1: In `ST_SEC`, `flags_o[0]` (SEC) rises on the clock edge that completes CYC_PER_SEC cycles counted from the edge that entered the state. It rises again every CYC_PER_SEC cycles after that.
- R2: In `ST_MIN`, `flags_o[0]` (SEC) is never set. Second events still advance the minute count.
- R3: `flags_o[1]` (MIN) rises on the same edge as the second event that completes SEC_PER_MIN seconds. This holds in both running states.
- R4: When `en_i` is low, the controller is in `ST_OFF`, both counters stay at zero and no flag is set. Flags already set keep their value.
- R5: When `en_i` goes from low to high, counting restarts from zero. The first second event then follows the R1 timing.
- R6: A cycle with `rd_i` high clears both flags on the next edge.
- R7: If a flag's set event and `rd_i` fall in the same cycle, that flag ends up set.
- R8: `irq_o` is high exactly when at least one flag is set.
- R9: A synchronous `rst_i` clears both flags and `irq_o` and returns the controller to `ST_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz time base clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Time base enable (mode register 2 bit 6) |
| sel_i | input | 1 | Rate select: 1 gives second and minute, 0 gives minute only (mode register 2 bit 5) |
| rd_i | input | 1 | One-cycle strobe when the interrupt register is read |
| flags_o | output | 2 | [1] MIN flag (interrupt register bit 7), [0] SEC flag (bit 6) |
| irq_o | output | 1 | Shared interrupt request, active high |

## Verification
The bench shrinks the ratios to 4 cycles per second and 3 seconds per minute so that whole minutes fit in a short run.

It aims a read strobe at the very cycle in which a second event and a minute event coincide. A design that lets clear win over set would lose both flags there.

It switches from second rate to minute rate in the middle of a second. A design that resets the chain on a rate change, or that keeps setting SEC, misses the expected MIN edge or shows a stray SEC.

It leaves the block disabled for many cycles and then re-enables it. A design that does not hold the chain at zero would fire early or while disabled.

Finally, it resets while a flag is set, to catch flags that survive reset.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_SEC = 2'd1,
        ST_MIN = 2'd2
    } tbase_state_e;
endpackage

// File: rtl/tbase_fsm.sv
module tbase_fsm
    import tbase_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         sel_i,
    output tbase_state_e state_o,
    output logic         run_o,
    output logic         sec_ok_o
);
    tbase_state_e state_q, state_d;

    // next-state decision: T_DISABLE, T_PICK_SEC, T_PICK_MIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_SEC, ST_MIN: begin
                if (!en_i)     state_d = ST_OFF;
                else if (sel_i) state_d = ST_SEC;
                else           state_d = ST_MIN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_OFF;
        else       state_q <= state_d;
    end

    always_comb begin
        run_o    = 1'b0;
        sec_ok_o = 1'b0;
        unique case (state_q)
            ST_OFF: begin run_o = 1'b0; sec_ok_o = 1'b0; end
            ST_SEC: begin run_o = 1'b1; sec_ok_o = 1'b1; end
            ST_MIN: begin run_o = 1'b1; sec_ok_o = 1'b0; end
            default: begin run_o = 1'b0; sec_ok_o = 1'b0; end
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/tbase_divider.sv
module tbase_divider #(
    parameter int unsigned LIMIT = 32768
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic step_i,
    output logic wrap_o
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);
    assign wrap_o  = run_i && step_i && at_last;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i)  cnt_q <= '0;
        else if (step_i)      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/tbase_flags.sv
module tbase_flags (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       set_min_i,
    input  logic       set_sec_i,
    input  logic       rd_i,
    output logic [1:0] flags_o
);
    logic [1:0] set_v;
    assign set_v = {set_min_i, set_sec_i};

    for (genvar i = 0; i < 2; i++) begin : g_flag
        always_ff @(posedge clk_i) begin
            if (rst_i)         flags_o[i] <= 1'b0;
            else if (set_v[i]) flags_o[i] <= 1'b1;
            else if (rd_i)     flags_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/tbase_timebase.sv
module tbase_timebase
    import tbase_pkg::*;
#(
    parameter int unsigned CYC_PER_SEC = 32768,
    parameter int unsigned SEC_PER_MIN = 60
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       sel_i,
    input  logic       rd_i,
    output logic [1:0] flags_o,
    output logic       irq_o
);
    tbase_state_e state;
    logic run, sec_ok, sec_evt, min_evt;

    tbase_fsm u_fsm (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .sel_i(sel_i),
        .state_o(state), .run_o(run), .sec_ok_o(sec_ok)
    );

    tbase_divider #(.LIMIT(CYC_PER_SEC)) u_presc (
        .clk_i(clk_i), .rst_i(rst_i), .run_i(run), .step_i(1'b1), .wrap_o(sec_evt)
    );

    tbase_divider #(.LIMIT(SEC_PER_MIN)) u_secs (
        .clk_i(clk_i), .rst_i(rst_i), .run_i(run), .step_i(sec_evt), .wrap_o(min_evt)
    );

    tbase_flags u_flags (
        .clk_i(clk_i), .rst_i(rst_i),
        .set_min_i(min_evt), .set_sec_i(sec_evt && sec_ok),
        .rd_i(rd_i), .flags_o(flags_o)
    );

    assign irq_o = flags_o[1] | flags_o[0];
endmodule

// File: rtl/tbase_checker.sv
module tbase_checker
    import tbase_pkg::*;
(
    input logic         clk_i,
    input logic         rst_i,
    input logic         rd_i,
    input logic [1:0]   flags_o,
    input tbase_state_e state,
    input logic         sec_evt,
    input logic         min_evt
);
    p_off_quiet_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_OFF) |-> (!sec_evt && !min_evt));

    p_min_needs_sec_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        min_evt |-> sec_evt);

    p_set_wins_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (min_evt && rd_i) |=> flags_o[1]);

    p_read_clears_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !sec_evt && !min_evt) |=> (flags_o == 2'b00));

    p_no_sec_in_min_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_MIN && !flags_o[0]) |=> !flags_o[0]);
endmodule

bind tbase_timebase tbase_checker u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .rd_i(rd_i), .flags_o(flags_o),
    .state(state), .sec_evt(sec_evt), .min_evt(min_evt)
);

// File: tb/sim_tbase_timebase.sv
module sim_tbase_timebase;
    localparam int unsigned CPS = 4;
    localparam int unsigned SPM = 3;
    localparam int NV = 18;

    logic clk = 1'b0;
    logic rst, en, sel, rd;
    logic [1:0] flags;
    logic irq;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tbase_timebase #(.CYC_PER_SEC(CPS), .SEC_PER_MIN(SPM)) u0 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .sel_i(sel), .rd_i(rd),
        .flags_o(flags), .irq_o(irq)
    );

    // {en, sel, rd, edges[7:0], req[3:0], exp_min, exp_sec}
    localparam logic [16:0] VEC [NV] = '{
        {3'b110, 8'd1,  4'd5, 2'b00},  // R5 enter second rate
        {3'b110, 8'd3,  4'd1, 2'b00},  // R1 not yet
        {3'b110, 8'd1,  4'd1, 2'b01},  // R1 first second
        {3'b111, 8'd1,  4'd6, 2'b00},  // R6 read clears
        {3'b110, 8'd3,  4'd1, 2'b01},  // R1 second second
        {3'b111, 8'd1,  4'd6, 2'b00},  // R6
        {3'b110, 8'd2,  4'd3, 2'b00},  // R3 before minute
        {3'b111, 8'd1,  4'd7, 2'b11},  // R7 set beats read, R3 minute
        {3'b111, 8'd1,  4'd6, 2'b00},  // R6 both cleared
        {3'b100, 8'd1,  4'd2, 2'b00},  // R2 switch to minute rate
        {3'b100, 8'd2,  4'd2, 2'b00},  // R2 second event, no SEC
        {3'b100, 8'd7,  4'd2, 2'b00},  // R2
        {3'b100, 8'd1,  4'd3, 2'b10},  // R3 minute in minute rate
        {3'b001, 8'd1,  4'd6, 2'b00},  // R6 read while disabling
        {3'b010, 8'd20, 4'd4, 2'b00},  // R4 disabled stays quiet
        {3'b110, 8'd1,  4'd5, 2'b00},  // R5 re-enable
        {3'b110, 8'd3,  4'd5, 2'b00},  // R5 counting from zero
        {3'b110, 8'd1,  4'd5, 2'b01}   // R5 first second after restart
    };

    task automatic check(input string req, input logic [1:0] exp_f);
        checks++;
        if (flags !== exp_f || irq !== (exp_f[1] | exp_f[0])) begin
            fails++;
            $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b",
                     req, flags, irq, exp_f, exp_f[1] | exp_f[0]);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; sel = 1'b0; rd = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset state", 2'b00);
        rst = 1'b0;
        for (int v = 0; v < NV; v++) begin
            en  = VEC[v][16];
            sel = VEC[v][15];
            rd  = VEC[v][14];
            repeat (int'(VEC[v][13:6])) @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[v][5:2], v), VEC[v][1:0]);
        end
        // R9: reset while SEC flag is set (R8 irq dropped too)
        rd = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 reset clears set flag", 2'b00);
        // R5/R1: enable held through reset, release, count restarts
        rst = 1'b0;
        repeat (4) @(posedge clk); @(negedge clk);
        check("R1 after reset not yet", 2'b00);
        @(posedge clk); @(negedge clk);
        check("R1 after reset first second", 2'b01);
        // R4: disable keeps existing flag
        en = 1'b0;
        repeat (10) @(posedge clk); @(negedge clk);
        check("R4 flag held while disabled", 2'b01);
        rd = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R6 read while disabled, R8 irq low", 2'b00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule